// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Master

This block sits between a synchronous client and an external byte-wide asynchronous static RAM. The RAM has a 17-bit address, an 8-bit bidirectional data bus and three active-low strobes: chip select, read-drive enable and write strobe. The client offers one request at a time through a valid/ready handshake. Each request carries an address, a write flag and write data. The block turns each request into a strobe sequence whose every interval is a whole number of clock cycles. Each count is derived from a picosecond timing parameter and the clock period parameter, rounding up.

A read holds chip select and the read-drive enable low until the address access time, the drive-enable access time and the minimum cycle time have all elapsed. The block then captures the data bus and returns it with a one-cycle response strobe. A write lowers chip select and the write strobe together and keeps the read-drive enable high. It drives data for the whole strobe. It raises the write strobe before chip select, so the write strobe's rising edge is the one that ends the write. After every cycle the address is held for a chip-select hold window. The data drivers stay off for a programmable turnaround after the RAM was last allowed to drive the bus.

The bidirectional bus is modelled as three signals: an input, an output and an output enable. The pad itself lives outside this block.

Top module: `asram_cycle_master`

## Requirements
- R1: After reset, chip select, read-drive enable and write strobe are all high (1), the data output enable is 0, the response strobe is 0 and ready is 1.
- R2: A read drives chip select low, read-drive enable low and write strobe high from the accepting edge for RD_CYC cycles. RD_CYC is the largest of ceil(T_AA/T_CLK), ceil(T_OE/T_CLK) and ceil(T_CYC/T_CLK), which is 9 at defaults. The data bus is captured on the last of those edges and returned with the response strobe high for exactly one cycle.
- R3: A write drives chip select and the write strobe low on the accepting edge. The read-drive enable stays high throughout, and the block drives the write data from that edge until chip select rises. The read-drive enable and the write strobe are never low together. The data drivers are never on while the read-drive enable is low.
- R4: The write strobe stays low for WP_CYC cycles. WP_CYC is the largest of the cycle counts for the strobe width, the data setup, the address setup and the cycle time, which is 9 at defaults.
- R5: In a write, the write strobe rises WAH_CYC cycles (1 at defaults) before chip select rises. Address and data stay driven in between. When chip select rises, the write strobe has already been high for at least one cycle.
- R6: The address does not change while chip select is low. After chip select rises, the address does not change for EAH_CYC cycles (2 at defaults).
- R7: Ready is low from the accepting edge until the hold window and the turnaround window have both elapsed, and chip select is high whenever ready is high.
- R8: The data drivers turn on no earlier than TURN_CYC cycles after the read-drive enable rose.
- R9: Data written to an address is returned by a later read of that address, for every single-bit address and for the all-zero and all-one addresses. A later write to the same address replaces the earlier data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Request taken on this edge when valid is also high |
| req_write_i | input | 1 | 1 for a write, 0 for a read |
| req_addr_i | input | AW | Request address |
| req_wdata_i | input | DW | Write data |
| rsp_valid_o | output | 1 | One-cycle strobe with read data |
| rsp_rdata_o | output | DW | Read data |
| mem_addr_o | output | AW | RAM address |
| mem_ce_n_o | output | 1 | RAM chip select, active low |
| mem_oe_n_o | output | 1 | RAM read-drive enable, active low |
| mem_we_n_o | output | 1 | RAM write strobe, active low |
| mem_dq_i | input | DW | Data bus as seen from the RAM |
| mem_dq_o | output | DW | Data driven towards the RAM |
| mem_dq_oe_o | output | 1 | Data driver enable |

## Verification
The embedded properties check, on every cycle, the strobe exclusions and the absence of bus contention. They also check address stability while chip select is low, the write strobe rising ahead of chip select, chip select being high whenever ready is high, and the single-cycle response strobe. Only the bench scenarios can show the exact strobe lengths, the address hold after chip select rises and the turnaround gap before the drivers turn on. The bench's RAM model returns valid data only from the cycle at which the access time has elapsed, so only its scenarios show that read data is captured no earlier. It also commits writes on the ending strobe edge, so only its scenarios show that the data stored and read back is correct.

// File: rtl/asram_pkg.sv
package asram_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_READ,
        PH_WRITE,
        PH_WREL,
        PH_HOLD
    } phase_e;

    // Whole clock cycles covering a picosecond interval, never below one.
    function automatic int unsigned ps_to_cyc(input int unsigned ps, input int unsigned clk_ps);
        int unsigned r;
        r = (ps + clk_ps - 1) / clk_ps;
        if (r < 1) r = 1;
        return r;
    endfunction

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/asram_down_counter.sv
module asram_down_counter #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/asram_cycle_master.sv
module asram_cycle_master
    import asram_pkg::*;
#(
    parameter int unsigned AW       = 17,
    parameter int unsigned DW       = 8,
    parameter int unsigned T_CLK    = 8000,   // clock period, ps
    parameter int unsigned T_AA     = 70000,  // address to read data
    parameter int unsigned T_OE     = 35000,  // read-drive enable to read data
    parameter int unsigned T_CYC    = 70000,  // minimum cycle
    parameter int unsigned T_WP     = 55000,  // write strobe width
    parameter int unsigned T_DW     = 30000,  // data setup to strobe rise
    parameter int unsigned T_AW     = 65000,  // address setup to strobe rise
    parameter int unsigned T_WAH    = 5000,   // address hold after strobe rise
    parameter int unsigned T_EAH    = 15000,  // address hold after select rise
    parameter int unsigned TURN_CYC = 1       // driver-off cycles after read drive
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid_i,
    output logic          req_ready_o,
    input  logic          req_write_i,
    input  logic [AW-1:0] req_addr_i,
    input  logic [DW-1:0] req_wdata_i,
    output logic          rsp_valid_o,
    output logic [DW-1:0] rsp_rdata_o,
    output logic [AW-1:0] mem_addr_o,
    output logic          mem_ce_n_o,
    output logic          mem_oe_n_o,
    output logic          mem_we_n_o,
    input  logic [DW-1:0] mem_dq_i,
    output logic [DW-1:0] mem_dq_o,
    output logic          mem_dq_oe_o
);

    localparam int unsigned RD_CYC  = umax(umax(ps_to_cyc(T_AA, T_CLK), ps_to_cyc(T_OE, T_CLK)),
                                           ps_to_cyc(T_CYC, T_CLK));
    localparam int unsigned WP_CYC  = umax(umax(ps_to_cyc(T_WP, T_CLK), ps_to_cyc(T_DW, T_CLK)),
                                           umax(ps_to_cyc(T_AW, T_CLK), ps_to_cyc(T_CYC, T_CLK)));
    localparam int unsigned WAH_CYC = ps_to_cyc(T_WAH, T_CLK);
    localparam int unsigned EAH_CYC = ps_to_cyc(T_EAH, T_CLK);
    localparam int unsigned TRN_CYC = (TURN_CYC < 1) ? 1 : TURN_CYC;
    localparam int unsigned MAX_CYC = umax(umax(RD_CYC, WP_CYC), umax(WAH_CYC, EAH_CYC));
    localparam int unsigned CW      = $clog2(MAX_CYC + 1);
    localparam int unsigned TW      = $clog2(TRN_CYC + 1);

    typedef struct packed {
        phase_e        phase;
        logic [AW-1:0] addr;
        logic [DW-1:0] dout;
        logic [DW-1:0] rdata;
        logic          ce_n;
        logic          oe_n;
        logic          we_n;
        logic          dq_oe;
        logic          rvalid;
    } ctl_t;

    ctl_t          s_d, s_q;
    logic          ph_load, ph_zero;
    logic [CW-1:0] ph_val;
    logic          trn_load, trn_zero;
    logic          ready;

    asram_down_counter #(.W(CW)) u_phase_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ph_load),
        .load_val (ph_val),
        .zero     (ph_zero)
    );

    asram_down_counter #(.W(TW)) u_turn_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (trn_load),
        .load_val (TW'(TRN_CYC)),
        .zero     (trn_zero)
    );

    assign ready = (s_q.phase == PH_IDLE) && trn_zero;

    always_comb begin
        s_d      = s_q;
        s_d.rvalid = 1'b0;
        ph_load  = 1'b0;
        ph_val   = '0;
        trn_load = 1'b0;
        case (s_q.phase)
            PH_IDLE: begin
                if (req_valid_i && ready) begin
                    s_d.addr = req_addr_i;
                    s_d.ce_n = 1'b0;
                    ph_load  = 1'b1;
                    if (req_write_i) begin
                        s_d.we_n  = 1'b0;
                        s_d.dq_oe = 1'b1;
                        s_d.dout  = req_wdata_i;
                        s_d.phase = PH_WRITE;
                        ph_val    = CW'(WP_CYC - 1);
                    end else begin
                        s_d.oe_n  = 1'b0;
                        s_d.phase = PH_READ;
                        ph_val    = CW'(RD_CYC - 1);
                    end
                end
            end
            PH_READ: begin
                if (ph_zero) begin
                    s_d.rdata  = mem_dq_i;
                    s_d.rvalid = 1'b1;
                    s_d.ce_n   = 1'b1;
                    s_d.oe_n   = 1'b1;
                    trn_load   = 1'b1;
                    s_d.phase  = PH_HOLD;
                    ph_load    = 1'b1;
                    ph_val     = CW'(EAH_CYC - 1);
                end
            end
            PH_WRITE: begin
                if (ph_zero) begin
                    s_d.we_n  = 1'b1;
                    s_d.phase = PH_WREL;
                    ph_load   = 1'b1;
                    ph_val    = CW'(WAH_CYC - 1);
                end
            end
            PH_WREL: begin
                if (ph_zero) begin
                    s_d.ce_n  = 1'b1;
                    s_d.dq_oe = 1'b0;
                    s_d.phase = PH_HOLD;
                    ph_load   = 1'b1;
                    ph_val    = CW'(EAH_CYC - 1);
                end
            end
            PH_HOLD: begin
                if (ph_zero) s_d.phase = PH_IDLE;
            end
            default: s_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.phase  <= PH_IDLE;
            s_q.addr   <= '0;
            s_q.dout   <= '0;
            s_q.rdata  <= '0;
            s_q.ce_n   <= 1'b1;
            s_q.oe_n   <= 1'b1;
            s_q.we_n   <= 1'b1;
            s_q.dq_oe  <= 1'b0;
            s_q.rvalid <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign req_ready_o = ready;
    assign rsp_valid_o = s_q.rvalid;
    assign rsp_rdata_o = s_q.rdata;
    assign mem_addr_o  = s_q.addr;
    assign mem_ce_n_o  = s_q.ce_n;
    assign mem_oe_n_o  = s_q.oe_n;
    assign mem_we_n_o  = s_q.we_n;
    assign mem_dq_o    = s_q.dout;
    assign mem_dq_oe_o = s_q.dq_oe;

    AST_OE_WE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_oe_n_o && !mem_we_n_o)); // R3
    AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe_o |-> mem_oe_n_o); // R3
    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n_o && !$past(mem_ce_n_o)) |-> $stable(mem_addr_o)); // R6
    AST_WE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_ce_n_o) |-> (mem_we_n_o && $past(mem_we_n_o))); // R5
    AST_READY_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready_o |-> mem_ce_n_o); // R7
    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |=> !rsp_valid_o); // R2

endmodule

// File: tb/asram_cycle_master_test.sv
`timescale 1ns/1ps
module asram_cycle_master_test;

    localparam int RD   = 9;
    localparam int WP   = 9;
    localparam int WAH  = 1;
    localparam int EAH  = 2;
    localparam int TURN = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [16:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, rsp_valid;
    logic [7:0]  rsp_rdata;
    logic [16:0] mem_addr;
    logic        ce_n, oe_n, we_n, dq_oe;
    logic [7:0]  dq_o, dq_i;

    int tests = 0;
    int fails = 0;

    always #4 clk = ~clk;

    asram_cycle_master #(.TURN_CYC(TURN)) uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid_i(req_valid), .req_ready_o(req_ready),
        .req_write_i(req_write), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
        .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
        .mem_addr_o(mem_addr), .mem_ce_n_o(ce_n), .mem_oe_n_o(oe_n), .mem_we_n_o(we_n),
        .mem_dq_i(dq_i), .mem_dq_o(dq_o), .mem_dq_oe_o(dq_oe)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // RAM model and bus monitors, evaluated on falling edges
    logic [7:0] store [int];
    logic [7:0] rd_model = 8'h00;
    int  ce_lo_cnt = 0;
    int  ce_hi_cnt = 100;
    int  oe_hi_cnt = 100;
    logic p_ce = 1'b1, p_we = 1'b1, p_dqoe = 1'b0;
    logic [16:0] p_addr = '0;
    int  mon_viol = 0;

    assign dq_i = (!ce_n && !oe_n && we_n && ce_lo_cnt >= RD) ? rd_model : 8'hEE;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!p_we && !p_ce && (we_n || ce_n)) begin
                if (!dq_oe) begin
                    mon_viol++;
                    chk(1'b0, "R3 data driven at write end", 32'(dq_oe), 32'd1);
                end
                store[int'(p_addr)] = dq_o;
            end
            if (mem_addr != p_addr && (!p_ce || ce_hi_cnt < EAH)) begin
                mon_viol++;
                chk(1'b0, "R6 address moved", 32'(ce_hi_cnt), 32'(EAH));
            end
            if (dq_oe && !p_dqoe && oe_hi_cnt < TURN) begin
                mon_viol++;
                chk(1'b0, "R8 turnaround", 32'(oe_hi_cnt), 32'(TURN));
            end
            if (dq_oe && !oe_n) begin
                mon_viol++;
                chk(1'b0, "R3 contention", 32'(oe_n), 32'd1);
            end
        end
        ce_lo_cnt = ce_n ? 0 : ce_lo_cnt + 1;
        ce_hi_cnt = !ce_n ? 0 : (ce_hi_cnt < 100 ? ce_hi_cnt + 1 : ce_hi_cnt);
        oe_hi_cnt = !oe_n ? 0 : (oe_hi_cnt < 100 ? oe_hi_cnt + 1 : oe_hi_cnt);
        rd_model  = store.exists(int'(mem_addr)) ? store[int'(mem_addr)] : 8'h00;
        p_ce = ce_n; p_we = we_n; p_dqoe = dq_oe; p_addr = mem_addr;
    end

    task automatic wait_ready();
        for (int i = 0; i < 64 && !req_ready; i++) @(negedge clk);
    endtask

    task automatic do_write(input logic [16:0] a, input logic [7:0] d);
        int  n;
        bit  rdy_seen;
        wait_ready();
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        chk(!ce_n && !we_n && oe_n && dq_oe && dq_o == d && mem_addr == a, "R3 write start",
            {ce_n, we_n, oe_n, dq_oe, dq_o}, {4'b0011, d});
        n = 1; rdy_seen = req_ready;
        for (int i = 0; i < 64 && !we_n; i++) begin
            @(negedge clk);
            if (!we_n) n++;
            rdy_seen |= req_ready;
        end
        chk(n == WP, "R4 strobe width", 32'(n), 32'(WP));
        chk(!ce_n && dq_oe && mem_addr == a, "R5 select held after strobe rise",
            {ce_n, dq_oe}, 2'b01);
        for (int i = 0; i < WAH; i++) @(negedge clk);
        chk(ce_n, "R5 select rise offset", 32'(ce_n), 32'd1);
        chk(!rdy_seen, "R7 ready low while busy", 32'(rdy_seen), 32'd0);
    endtask

    task automatic do_read(input logic [16:0] a, input logic [7:0] exp);
        int  n;
        int  r;
        bit  rdy_seen;
        wait_ready();
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        chk(!ce_n && !oe_n && we_n && !dq_oe && mem_addr == a, "R2 read strobes",
            {ce_n, oe_n, we_n, dq_oe}, 4'b0010);
        n = 0; rdy_seen = req_ready;
        for (int i = 0; i < 64 && !rsp_valid; i++) begin
            @(negedge clk);
            n++;
            rdy_seen |= req_ready;
        end
        chk(n == RD, "R2 read latency", 32'(n), 32'(RD));
        chk(rsp_rdata == exp, "R9 read data", 32'(rsp_rdata), 32'(exp));
        chk(ce_n && oe_n, "R2 strobes released", {ce_n, oe_n}, 2'b11);
        r = 0;
        for (int i = 0; i < 64 && !req_ready; i++) begin
            @(negedge clk);
            r++;
            if (i == 0) chk(!rsp_valid, "R2 single response strobe", 32'(rsp_valid), 32'd0);
        end
        chk(r == TURN, "R7 R8 ready after read", 32'(r), 32'(TURN));
        chk(!rdy_seen, "R7 ready low while busy", 32'(rdy_seen), 32'd0);
    endtask

    function automatic logic [7:0] pat(input logic [16:0] a, input int k);
        return a[7:0] ^ a[15:8] ^ {7'd0, a[16]} ^ 8'(8'h5A + k * 37);
    endfunction

    initial begin
        #(200000 * 8);
        chk(1'b0, "watchdog", 32'd0, 32'd1);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [16:0] addrs [19];
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ce_n && oe_n && we_n && !dq_oe && !rsp_valid && req_ready, "R1 reset state",
            {ce_n, oe_n, we_n, dq_oe, rsp_valid, req_ready}, 6'b111001);
        for (int i = 0; i < 17; i++) addrs[i] = 17'(1) << i;
        addrs[17] = '0;
        addrs[18] = '1;
        for (int i = 0; i < 19; i++) do_write(addrs[i], pat(addrs[i], 0));
        for (int i = 18; i >= 0; i--) do_read(addrs[i], pat(addrs[i], 0));
        for (int i = 0; i < 19; i++) begin
            do_write(addrs[i], pat(addrs[i], 1));
            do_read(addrs[i], pat(addrs[i], 1));
        end
        do_read(17'h0ABCD, 8'h00);
        do_write(17'h0ABCD, 8'hC3);
        do_write(17'h0ABCD, 8'h3C);
        do_read(17'h0ABCD, 8'h3C);
        repeat (4) @(negedge clk);
        chk(mon_viol == 0, "R3 R6 R8 bus monitors", 32'(mon_viol), 32'd0);
        chk(req_ready && ce_n && !dq_oe, "R7 idle after traffic",
            {req_ready, ce_n, dq_oe}, 3'b110);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule